// File: doc/BRIEF.md
# Coherent Byte-Read Input Capture

This block samples a free-running 16-bit counter into a capture register when a rising edge is seen on an asynchronous capture input. The host reaches the 16-bit result through an 8-bit read port, one byte per access. Byte select 0 addresses the most significant byte, at the lower offset. Byte select 1 addresses the least significant byte, at offset 1.

A two-state guard keeps the two reads of one sample consistent. In state Open, captures are accepted. A strobed high-byte read takes transition T_LOCK into state Held. While the guard is in Held, every capture edge is thrown away. A strobed low-byte read takes transition T_UNLOCK back to Open. The host therefore reads the high byte first and the low byte second, and both bytes always come from the same sample.

A capture flag shows that a new sample has been taken since the last low-byte read.

Top module: `capcoh_top`

## Requirements
- R1: While rst_n is low, the capture register reads 0 in both bytes, cap_flag is 0 and the guard is in Open.
- R2: If cap_in is sampled low at clock edge n-1 and high at edge n, and the guard is Open, the value on count_in at edge n+2 is stored in the capture register.
- R3: rd_data shows bits 15:8 of the capture register when rd_sel is 0 and bits 7:0 when rd_sel is 1. rd_data follows rd_sel in the same cycle, with or without rd_stb.
- R4: A strobed high-byte read (rd_stb=1, rd_sel=0) moves the guard to Held. A capture that falls in that same cycle is discarded, and so is any capture while the guard is Held.
- R5: A strobed low-byte read (rd_stb=1, rd_sel=1) in Held returns the guard to Open. A capture in that same cycle is still discarded, and captures in later cycles are accepted.
- R6: A strobed low-byte read in Open returns the low byte and leaves the guard in Open, so the next capture edge is accepted.
- R7: cap_flag goes to 1 in the cycle after an accepted capture. It goes to 0 after a strobed low-byte read. When both happen in the same cycle, the capture wins.
- R8: Capture edges discarded while the guard is Held are not stored or replayed. After release, the register keeps its earlier value until a fresh edge arrives.
- R9: A falling edge on cap_in, or a level held steady, never causes a capture.
- R10: Repeated strobed high-byte reads in Held keep the guard in Held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_in | input | 1 | Asynchronous capture request, rising edge active |
| count_in | input | 16 | Free-running counter value |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_sel | input | 1 | Byte select: 0 high byte, 1 low byte |
| rd_data | output | 8 | Selected byte of the capture register |
| cap_flag | output | 1 | New-sample flag |

## Verification
The hardest cases to reach are the ones where a capture falls in exactly the same cycle as a strobed read. There is one case for a high-byte read and one for a low-byte read, and the capture must be discarded in both. Because of the synchroniser, the capture lands two clocks after cap_in is first seen high. The stimulus therefore raises cap_in two steps ahead of the planned strobe. A long random stretch then mixes edges and strobes at every relative phase, and the bench model follows each case cycle by cycle.

// File: rtl/capcoh_pkg.sv
package capcoh_pkg;
    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } guard_state_t;
endpackage

// File: rtl/capcoh_edge_sync.sv
module capcoh_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-2:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/capcoh_guard_fsm.sv
module capcoh_guard_fsm
    import capcoh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    input  logic high_rd,
    input  logic low_rd,
    output logic accept,
    output logic locked
);
    guard_state_t state, next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_OPEN: if (high_rd) next_state = ST_HELD;
            ST_HELD: if (low_rd)  next_state = ST_OPEN;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        locked = 1'b0;
        unique case (state)
            ST_OPEN: accept = edge_seen & ~high_rd;
            ST_HELD: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/capcoh_sample_reg.sv
module capcoh_sample_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             low_rd,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] sample,
    output logic             flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample <= '0;
            flag   <= 1'b0;
        end else begin
            if (accept) sample <= count_in;
            if (accept)      flag <= 1'b1;
            else if (low_rd) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/capcoh_top.sv
module capcoh_top #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_in,
    input  logic [2*BYTE_W-1:0] count_in,
    input  logic                rd_stb,
    input  logic                rd_sel,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                cap_flag
);
    localparam int CNT_W = 2 * BYTE_W;

    logic             edge_seen;
    logic             cap_accept;
    logic             locked;
    logic [CNT_W-1:0] cap_val;
    logic             high_rd;
    logic             low_rd;

    assign high_rd = rd_stb & ~rd_sel;
    assign low_rd  = rd_stb &  rd_sel;

    capcoh_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .rise  (edge_seen)
    );

    capcoh_guard_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (edge_seen),
        .high_rd   (high_rd),
        .low_rd    (low_rd),
        .accept    (cap_accept),
        .locked    (locked)
    );

    capcoh_sample_reg #(.CNT_W(CNT_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (cap_accept),
        .low_rd   (low_rd),
        .count_in (count_in),
        .sample   (cap_val),
        .flag     (cap_flag)
    );

    assign rd_data = rd_sel ? cap_val[BYTE_W-1:0] : cap_val[CNT_W-1:BYTE_W];
endmodule

// File: rtl/capcoh_checker.sv
module capcoh_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic             rd_sel,
    input logic [CNT_W-1:0] count_in,
    input logic             cap_flag,
    input logic [CNT_W-1:0] cap_val,
    input logic             locked,
    input logic             cap_accept
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (cap_val == '0 && !cap_flag && !locked));

    // R2
    a_r2_takes_count: assert property (@(posedge clk) disable iff (!rst_n)
        cap_accept |=> cap_val == $past(count_in));

    // R4
    a_r4_high_read_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_sel) |=> locked);

    // R4, R8
    a_r4_held_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cap_val));

    // R5
    a_r5_low_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel) |=> !locked);

    // R6
    a_r6_open_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(rd_stb && !rd_sel)) |=> !locked);

    // R7
    a_r7_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_accept |=> cap_flag);

    // R7
    a_r7_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel && !cap_accept) |=> !cap_flag);
endmodule

bind capcoh_top capcoh_checker #(.CNT_W(2*BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .rd_sel     (rd_sel),
    .count_in   (count_in),
    .cap_flag   (cap_flag),
    .cap_val    (cap_val),
    .locked     (locked),
    .cap_accept (cap_accept)
);

// File: tb/capcoh_top_bench.sv
`timescale 1ns/1ps
module capcoh_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_in = 1'b0;
    logic [15:0] count_in = '0;
    logic        rd_stb = 1'b0;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd_data;
    logic        cap_flag;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] cnt = 16'h12F0;

    // behavioural reference model
    bit          hist[$];
    logic [15:0] m_val = '0;
    bit          m_flag = 0;
    bit          m_lock = 0;

    // hook for directed checks
    bit          chk_en = 0;
    string       chk_tag;
    logic [7:0]  chk_byte;
    bit          chk_flag;

    always #2.5 clk = ~clk;

    capcoh_top u_capcoh_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .count_in (count_in),
        .rd_stb   (rd_stb),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .cap_flag (cap_flag)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit e;
        bit acc;
        e   = hist[1] && !hist[0];
        acc = e && !m_lock && !(rd_stb && !rd_sel);
        if (acc) m_val = count_in;
        if (acc) m_flag = 1;
        else if (rd_stb && rd_sel) m_flag = 0;
        if (rd_stb && !rd_sel) m_lock = 1;
        else if (rd_stb && rd_sel) m_lock = 0;
        hist.push_back(cap_in);
        void'(hist.pop_front());
    endtask

    task automatic step(input logic c, input logic s, input logic sel);
        @(negedge clk);
        cap_in = c; rd_stb = s; rd_sel = sel;
        count_in = cnt; cnt = cnt + 16'd1;
        #1;
        check("R3 rd_data vs model", {8'h0, rd_data}, {8'h0, (sel ? m_val[7:0] : m_val[15:8])});
        check("R7 cap_flag vs model", {15'h0, cap_flag}, {15'h0, m_flag});
        if (chk_en) begin
            check(chk_tag, {8'h0, rd_data}, {8'h0, chk_byte});
            check(chk_tag, {15'h0, cap_flag}, {15'h0, chk_flag});
            chk_en = 0;
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic look(input string tag, input logic sel, input logic [7:0] b, input bit f);
        chk_en = 1; chk_tag = tag; chk_byte = b; chk_flag = f;
        step(cap_in, 1'b0, sel);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(cap_in, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v1;
        logic [15:0] v2;
        hist = '{0, 0, 0};
        rst_n = 1'b0;
        #12;
        check("R1 reset high byte", {8'h0, rd_data}, 16'h0);
        check("R1 reset flag", {15'h0, cap_flag}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R2: capture of count two edges after the rising sample
        step(1'b1, 1'b0, 1'b0);
        v1 = cnt - 16'd1 + 16'd2;
        idle(3);
        look("R2 high byte", 1'b0, v1[15:8], 1'b1);
        look("R2 low byte",  1'b1, v1[7:0], 1'b1);

        // R9: falling edge and steady level do nothing
        step(1'b0, 1'b0, 1'b0);
        idle(5);
        look("R9 no capture on fall", 1'b1, v1[7:0], 1'b1);

        // R4, R8: lock, then an edge is discarded
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        idle(4);
        step(1'b0, 1'b1, 1'b0);   // R10 repeated high read
        step(1'b1, 1'b0, 1'b0);
        idle(4);
        look("R4 held keeps sample", 1'b1, v1[7:0], 1'b1);
        step(1'b1, 1'b1, 1'b1);   // release
        idle(5);
        look("R8 no replay after release", 1'b0, v1[15:8], 1'b0);

        // R5: new edge after release is accepted
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        v2 = cnt - 16'd1 + 16'd2;
        idle(3);
        look("R5 capture after release", 1'b1, v2[7:0], 1'b1);

        // R6: low read while open leaves guard open
        step(1'b0, 1'b1, 1'b1);
        look("R6 flag cleared by low read", 1'b1, v2[7:0], 1'b0);
        step(1'b1, 1'b0, 1'b0);
        v1 = cnt - 16'd1 + 16'd2;
        idle(3);
        look("R6 next edge accepted", 1'b0, v1[15:8], 1'b1);

        // R4: capture coinciding with high read is discarded
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        idle(2);
        step(1'b1, 1'b1, 1'b1);
        look("R4 coincident capture dropped", 1'b1, v1[7:0], 1'b0);

        // R5: capture coinciding with releasing low read is discarded
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        idle(2);
        look("R5 coincident release drops capture", 1'b1, v1[7:0], 1'b0);

        // R7: capture and low read together, set wins
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        v2 = cnt - 16'd1 + 16'd2;
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        look("R7 set wins over clear", 1'b1, v2[7:0], 1'b1);

        // mixed random stretch, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            logic c, s, sl;
            c  = ($urandom % 3) == 0 ? ~cap_in : cap_in;
            s  = ($urandom % 5) == 0;
            sl = $urandom % 2;
            step(c, s, sl);
        end

        finish_run();
    end
endmodule